// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a frame-relay framer by walking a circular list of transmit descriptors that a host processor fills in. Each descriptor holds four 16-bit words in an internal dual-port descriptor store. The host reaches that store, and two ring configuration registers, through a simple word-wide register port. Once the host has filled a descriptor and handed it over, it strobes a transmit demand. The engine then reads the descriptor, fetches the buffer bytes one at a time through a synchronous byte read port, and offers them downstream on a valid/ready byte stream. The first byte of a frame carries a start flag and the frame's four address-header control bits. The frame closes with a separate end beat that carries no data.

When a buffer has been sent, the engine writes a completion status word and clears the ownership flag, so the descriptor belongs to the host again. It can then raise a one-cycle interrupt. It chains buffers into one frame, wraps either at a marked descriptor or at the programmed ring size, drops discard-eligible frames while congestion is signalled, and flags an underflow when a chained frame runs into a descriptor the host has not released.

Descriptor word 0 holds these fields:

| Bits | Meaning |
|------|---------|
| 15 | ownership: 1 means the engine owns the descriptor |
| 14 | last slot of the ring |
| 12 | last buffer of the frame |
| 13, 11, 10, 9 | C/R, FECN, BECN, DE |
| 8 | interrupt suppress |
| 7:0 | buffer address bits 23:16 |

Word 1 holds address bits 15:0. Word 2 holds the byte count. Word 3 holds the status: bit 0 is done and bit 1 is underflow.

Top module: `txd_ring_engine`

## Requirements
- R1: A descriptor whose word 0 bit 15 is 0 is never processed. The engine emits no beat for it, leaves all four of its words unchanged, and stops there.
- R2: After a buffer is finished, word 0 reads back with bit 15 cleared and all other bits unchanged. Word 3 reads back with bit 0 set.
- R3: After the descriptor in ring position `ring_last`, or after any descriptor with word 0 bit 14 set, the next descriptor fetched is the one at slot `ring_base`. Slots outside the ring are never touched.
- R4: A descriptor with word 0 bit 12 at 0 continues its frame into the next descriptor's buffer. `out_sof` marks only the first data byte of the frame. One end beat (`out_end`=1) follows the last data byte. A frame with no data bytes produces no beats.
- R5: `out_hdr` = {C/R, FECN, BECN, DE} = word 0 bits {13,11,10,9} of the frame's first descriptor. It is presented with the `out_sof` byte.
- R6: If `congest` is 1 when the first descriptor of a frame is read and its DE bit is 1, the frame sends no beats. Its descriptors are still returned as in R2.
- R7: Each returned descriptor raises `irq` for exactly one cycle, unless word 0 bit 8 is set. In that case it raises no interrupt.
- R8: Data bytes are read from address {word0[7:0], word1} + i for i = 0 to count-1. At most one read is outstanding, and none is issued while a byte is being offered. A count of 0 sends nothing.
- R9: Underflow occurs when a chained frame reaches a descriptor it does not own. The engine then emits an end beat with `out_abort`=1 (if any data had been sent) and writes word 3 of the previous descriptor as 3. It raises `irq` whatever that descriptor's bit 8 holds, then idles. The next demand re-reads the same descriptor as the first of a new frame.
- R10: Reset sets `ring_base` to 0 and `ring_last` to NDESC-1, points the engine at ring position 0, and deasserts `out_valid` and `irq`.
- R11: While `out_valid` is 1 and `out_ready` is 0, the beat (data, start and end flags) holds unchanged.
- R12: From idle, the engine fetches nothing until `tx_demand` is pulsed. It then keeps walking until it meets a descriptor it does not own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| host_we | input | 1 | host write strobe |
| host_addr | input | 7 | bit 6 = 0: descriptor word {slot, word}; bit 6 = 1: register (bit 0 = 0 base, 1 last position) |
| host_wdata | input | 16 | host write data |
| host_rdata | output | 16 | host read data, one cycle after the address |
| tx_demand | input | 1 | start-polling strobe |
| congest | input | 1 | congestion mode: drop DE frames |
| mem_rd | output | 1 | buffer byte read request |
| mem_addr | output | 24 | buffer byte address |
| mem_rdata | input | 8 | read byte, valid the cycle after `mem_rd` |
| out_valid | output | 1 | beat valid |
| out_ready | input | 1 | downstream accepts beat |
| out_data | output | 8 | data byte |
| out_sof | output | 1 | first byte of frame |
| out_hdr | output | 4 | {C/R, FECN, BECN, DE} |
| out_end | output | 1 | end-of-frame beat (no data) |
| out_abort | output | 1 | end beat closes a frame cut short by underflow |
| irq | output | 1 | descriptor-returned interrupt pulse |

## Verification
The bound checker watches, on every cycle, the handshake rules of the byte stream. It checks that a held beat stays stable, that a start flag never rides on an end beat and that an abort comes only with an end beat. It also checks that the interrupt lasts one cycle and that buffer reads are single and never overlap an offered byte. Ownership handback, status contents, header sampling from the first descriptor, congestion drops, both wrap conditions, chaining, underflow recovery and the effect of the demand strobe depend on descriptor contents and order. Only the bench's scenarios show these, by reading the descriptors back and comparing the collected beats.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int W0_OWN   = 15;
  localparam int W0_WRAP  = 14;
  localparam int W0_CR    = 13;
  localparam int W0_LASTB = 12;
  localparam int W0_FECN  = 11;
  localparam int W0_BECN  = 10;
  localparam int W0_DE    = 9;
  localparam int W0_QUIET = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_RA, S_RB, S_RC, S_RD, S_RDY, S_MW, S_CAP, S_OUT, S_END, S_WS, S_WO
  } st_t;

  typedef enum logic [1:0] {A_STREAM, A_NEXT, A_IDLE} aft_t;
endpackage

// File: rtl/txd_desc_ram.sv
module txd_desc_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    if (b_we) mem[b_addr] <= b_wd;
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/txd_host_regs.sv
module txd_host_regs #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rg_sel,
  input  logic          rg_we,
  input  logic          rg_pick,
  input  logic [IW-1:0] rg_wd,
  input  logic [15:0]   ram_rd,
  output logic [15:0]   host_rdata,
  output logic [IW-1:0] ring_base,
  output logic [IW-1:0] ring_last
);
  logic sel_q, pick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base <= '0;
      ring_last <= '1;
      sel_q     <= 1'b0;
      pick_q    <= 1'b0;
    end else begin
      sel_q  <= rg_sel;
      pick_q <= rg_pick;
      if (rg_we && rg_sel) begin
        if (rg_pick) ring_last <= rg_wd;
        else         ring_base <= rg_wd;
      end
    end
  end

  assign host_rdata = sel_q ? 16'(pick_q ? ring_last : ring_base) : ram_rd;
endmodule

// File: rtl/txd_walker.sv
module txd_walker
  import txd_pkg::*;
#(
  parameter int IW    = 4,
  parameter int BUFAW = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_demand,
  input  logic             congest,
  input  logic [IW-1:0]    ring_base,
  input  logic [IW-1:0]    ring_last,
  output logic [IW+1:0]    e_addr,
  output logic             e_we,
  output logic [15:0]      e_wd,
  input  logic [15:0]      e_rd,
  output logic             mem_rd,
  output logic [BUFAW-1:0] mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic [3:0]       out_hdr,
  output logic             out_end,
  output logic             out_abort,
  output logic             irq
);
  st_t             st;
  aft_t            after;
  logic [IW-1:0]   ptr, cur_idx, wb_idx;
  logic [15:0]     cur_w0, wb_w0, len, cnt;
  logic [BUFAW-1:0] buf_a;
  logic            pend, started, drop, wb_err;
  logic [3:0]      hdr;

  logic [IW-1:0] slot, nxt;
  assign slot = ring_base + ptr;
  assign nxt  = (cur_w0[W0_WRAP] || ptr == ring_last) ? '0 : ptr + 1'b1;

  always_comb begin
    e_we = 1'b0;
    e_wd = '0;
    case (st)
      S_RB:    e_addr = {cur_idx, 2'd1};
      S_RC:    e_addr = {cur_idx, 2'd2};
      S_WS:    begin e_addr = {wb_idx, 2'd3}; e_we = 1'b1; e_wd = {14'd0, wb_err, 1'b1}; end
      S_WO:    begin e_addr = {wb_idx, 2'd0}; e_we = 1'b1; e_wd = wb_w0 & 16'h7FFF; end
      default: e_addr = {slot, 2'd0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; after <= A_NEXT; ptr <= '0; cur_idx <= '0; wb_idx <= '0;
      cur_w0 <= '0; wb_w0 <= '0; len <= '0; cnt <= '0; buf_a <= '0;
      pend <= 1'b0; started <= 1'b0; drop <= 1'b0; wb_err <= 1'b0; hdr <= '0;
      mem_rd <= 1'b0; mem_addr <= '0; out_valid <= 1'b0; out_data <= '0;
      out_sof <= 1'b0; out_hdr <= '0; out_end <= 1'b0; out_abort <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: if (tx_demand) st <= S_RA;
        S_RA: begin
          cur_idx <= slot;
          st      <= S_RB;
        end
        S_RB: begin
          if (e_rd[W0_OWN]) begin
            cur_w0 <= e_rd;
            if (!pend) begin
              hdr     <= {e_rd[W0_CR], e_rd[W0_FECN], e_rd[W0_BECN], e_rd[W0_DE]};
              drop    <= congest && e_rd[W0_DE];
              started <= 1'b0;
            end
            st <= S_RC;
          end else if (pend) begin
            wb_err <= 1'b1;
            after  <= A_IDLE;
            if (started) begin
              out_valid <= 1'b1; out_end <= 1'b1; out_abort <= 1'b1;
              st <= S_END;
            end else st <= S_WS;
          end else st <= S_IDLE;
        end
        S_RC: begin
          buf_a <= {cur_w0[7:0], e_rd};
          st    <= S_RD;
        end
        S_RD: begin
          len <= e_rd;
          cnt <= '0;
          if (pend) begin
            after <= A_STREAM;
            st    <= S_WS;
          end else st <= S_RDY;
        end
        S_RDY: begin
          if (drop || cnt == len) begin
            ptr    <= nxt;
            wb_idx <= cur_idx;
            wb_w0  <= cur_w0;
            wb_err <= 1'b0;
            if (cur_w0[W0_LASTB]) begin
              after <= A_NEXT;
              if (started && !drop) begin
                out_valid <= 1'b1; out_end <= 1'b1; out_abort <= 1'b0;
                st <= S_END;
              end else st <= S_WS;
            end else begin
              pend <= 1'b1;
              st   <= S_RA;
            end
          end else begin
            mem_rd   <= 1'b1;
            mem_addr <= buf_a + BUFAW'(cnt);
            st       <= S_MW;
          end
        end
        S_MW: begin
          mem_rd <= 1'b0;
          st     <= S_CAP;
        end
        S_CAP: begin
          out_valid <= 1'b1;
          out_data  <= mem_rdata;
          out_sof   <= !started;
          out_hdr   <= hdr;
          started   <= 1'b1;
          st        <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          out_sof   <= 1'b0;
          cnt       <= cnt + 1'b1;
          st        <= S_RDY;
        end
        S_END: if (out_ready) begin
          out_valid <= 1'b0; out_end <= 1'b0; out_abort <= 1'b0;
          started   <= 1'b0;
          st        <= S_WS;
        end
        S_WS: st <= S_WO;
        S_WO: begin
          irq  <= !wb_w0[W0_QUIET] || wb_err;
          pend <= 1'b0;
          case (after)
            A_STREAM: st <= S_RDY;
            A_NEXT:   st <= S_RA;
            default:  st <= S_IDLE;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine #(
  parameter int NDESC = 16,
  parameter int BUFAW = 24,
  localparam int IW  = $clog2(NDESC),
  localparam int HAW = IW + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [HAW-1:0]   host_addr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  input  logic             tx_demand,
  input  logic             congest,
  output logic             mem_rd,
  output logic [BUFAW-1:0] mem_addr,
  input  logic [7:0]       mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic [3:0]       out_hdr,
  output logic             out_end,
  output logic             out_abort,
  output logic             irq
);
  logic [IW-1:0] ring_base, ring_last;
  logic [15:0]   a_rd, b_rd, b_wd;
  logic [IW+1:0] b_addr;
  logic          b_we;

  txd_desc_ram #(.AW(IW + 2), .DW(16)) u_ram (
    .clk(clk),
    .a_we(host_we && !host_addr[HAW-1]), .a_addr(host_addr[IW+1:0]),
    .a_wd(host_wdata), .a_rd(a_rd),
    .b_we(b_we), .b_addr(b_addr), .b_wd(b_wd), .b_rd(b_rd)
  );

  txd_host_regs #(.IW(IW)) u_regs (
    .clk(clk), .rst(rst), .rg_sel(host_addr[HAW-1]), .rg_we(host_we),
    .rg_pick(host_addr[0]), .rg_wd(host_wdata[IW-1:0]), .ram_rd(a_rd),
    .host_rdata(host_rdata), .ring_base(ring_base), .ring_last(ring_last)
  );

  txd_walker #(.IW(IW), .BUFAW(BUFAW)) u_walk (
    .clk(clk), .rst(rst), .tx_demand(tx_demand), .congest(congest),
    .ring_base(ring_base), .ring_last(ring_last),
    .e_addr(b_addr), .e_we(b_we), .e_wd(b_wd), .e_rd(b_rd),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_hdr(out_hdr), .out_end(out_end),
    .out_abort(out_abort), .irq(irq)
  );
endmodule

// File: rtl/txd_ring_engine_chk.sv
module txd_ring_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_end,
  input logic       out_abort,
  input logic       irq,
  input logic       mem_rd
);
  // R11: a stalled beat holds
  a_r11_hold_beat: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_end)));

  // R4: the start flag rides on data beats only
  a_r4_sof_not_end: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> (out_valid && !out_end));

  // R9: abort appears only on an offered end beat
  a_r9_abort_on_end: assert property (@(posedge clk) disable iff (rst)
    out_abort |-> (out_valid && out_end));

  // R7: interrupt is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R8: one read at a time, never while a byte is offered
  a_r8_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  a_r8_no_read_while_offer: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !out_valid);
endmodule

bind txd_ring_engine txd_ring_engine_chk u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_end(out_end),
  .out_abort(out_abort), .irq(irq), .mem_rd(mem_rd)
);

// File: tb/tb_txd_ring_engine.sv
module tb_txd_ring_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        tx_demand = 1'b0;
  logic        congest = 1'b0;
  logic        mem_rd;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_sof;
  logic [3:0]  out_hdr;
  logic        out_end;
  logic        out_abort;
  logic        irq;

  always #2.5 clk = ~clk;

  txd_ring_engine dut (.*);

  function automatic logic [7:0] bytef(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= bytef(mem_addr);

  int n_chk = 0, n_fail = 0, nb = 0, irq_cnt = 0, stall_cnt = 0;
  bit stall = 0, finished = 0;
  logic [7:0] bd [64];
  logic [3:0] bh [64];
  bit bs [64], be [64], ba [64];

  always @(negedge clk) begin
    if (stall) begin
      stall_cnt++;
      out_ready = (stall_cnt % 3) != 0;
    end else out_ready = 1'b1;
    if (!rst) begin
      if (out_valid && out_ready && nb < 64) begin
        bd[nb] = out_data; bh[nb] = out_hdr; bs[nb] = out_sof;
        be[nb] = out_end;  ba[nb] = out_abort; nb++;
      end
      if (irq) irq_cnt++;
    end
  end

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic hw(logic [6:0] a, logic [15:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic hr(logic [6:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  function automatic logic [15:0] mk_w0(bit own, bit wrap, bit lastb, logic [3:0] h, bit quiet, logic [23:0] a);
    logic [15:0] w = '0;
    w[15] = own; w[14] = wrap; w[13] = h[3]; w[12] = lastb;
    w[11] = h[2]; w[10] = h[1]; w[9] = h[0]; w[8] = quiet; w[7:0] = a[23:16];
    return w;
  endfunction

  task automatic put_desc(int slot, logic [15:0] w0, logic [23:0] a, logic [15:0] n);
    hw(7'(slot * 4 + 3), 16'h0);
    hw(7'(slot * 4 + 2), n);
    hw(7'(slot * 4 + 1), a[15:0]);
    hw(7'(slot * 4), w0);
  endtask

  task automatic demand();
    @(negedge clk); tx_demand = 1'b1;
    @(negedge clk); tx_demand = 1'b0;
  endtask

  task automatic clear_obs();
    @(negedge clk); nb = 0; irq_cnt = 0;
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  // counts mismatching data bytes starting at beat index off
  task automatic check_bytes(string r, logic [23:0] a, int n, int off);
    int bad = 0;
    for (int i = 0; i < n; i++) if (bd[off + i] !== bytef(a + 24'(i))) bad++;
    check(r, bad, 0);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // {hdr[3:0], quiet, congest, len[7:0], exp_bytes[7:0], exp_irq}
  localparam logic [22:0] TBL [6] = '{
    {4'b1010, 1'b0, 1'b0, 8'd3, 8'd3, 1'b1},
    {4'b0101, 1'b0, 1'b0, 8'd2, 8'd2, 1'b1},
    {4'b0001, 1'b0, 1'b1, 8'd4, 8'd0, 1'b1},
    {4'b0000, 1'b1, 1'b0, 8'd0, 8'd0, 1'b0},
    {4'b1100, 1'b1, 1'b0, 8'd5, 8'd5, 1'b0},
    {4'b1111, 1'b0, 1'b1, 8'd2, 8'd0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] w0;
    logic [23:0] a;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R10 irq after reset", int'(irq), 0);
    hr(7'h40, rd); check("R10 ring_base reset", int'(rd), 0);
    hr(7'h41, rd); check("R10 ring_last reset", int'(rd), 15);

    for (int i = 0; i < 64; i++) hw(7'(i), 16'h0);

    // table walk: single-buffer frames in slots 0..5 (R2 R5 R6 R7 R8 R11)
    for (int k = 0; k < 6; k++) begin
      logic [22:0] t;
      int en;
      t  = TBL[k];
      a  = 24'h100000 + 24'(k) * 24'h001100;
      w0 = mk_w0(1'b1, 1'b0, 1'b1, t[22:19], t[18], a);
      put_desc(k, w0, a, 16'(t[16:9]));
      congest = t[17];
      stall   = (k == 4);
      clear_obs();
      demand();
      settle();
      stall = 0;
      en = int'(t[8:1]);
      check($sformatf("R6 R8 beats entry %0d", k), nb, (en > 0) ? en + 1 : 0);
      if (en > 0) begin
        check_bytes($sformatf("R8 R11 data entry %0d", k), a, en, 0);
        check($sformatf("R5 sof entry %0d", k), int'(bs[0]), 1);
        check($sformatf("R5 hdr entry %0d", k), int'(bh[0]), int'(t[22:19]));
        check($sformatf("R4 end entry %0d", k), int'(be[en]), 1);
      end
      check($sformatf("R7 irq entry %0d", k), irq_cnt, int'(t[0]));
      hr(7'(k * 4), rd);     check($sformatf("R2 owner cleared entry %0d", k), int'(rd), int'(w0 & 16'h7FFF));
      hr(7'(k * 4 + 3), rd); check($sformatf("R2 status entry %0d", k), int'(rd), 1);
    end
    congest = 0;

    // R4: three-buffer chain in slots 6,7,8 (lengths 2,0,3)
    put_desc(6, mk_w0(1, 0, 0, 4'b1010, 0, 24'h200000), 24'h200000, 16'd2);
    put_desc(7, mk_w0(1, 0, 0, 4'b0101, 0, 24'h210000), 24'h210000, 16'd0);
    put_desc(8, mk_w0(1, 0, 1, 4'b0101, 0, 24'h220040), 24'h220040, 16'd3);
    clear_obs(); demand(); settle();
    check("R4 chain beats", nb, 6);
    check_bytes("R4 chain first buffer", 24'h200000, 2, 0);
    check_bytes("R4 chain last buffer", 24'h220040, 3, 2);
    check("R4 single sof", int'(bs[0]) + int'(bs[1]) + int'(bs[2]) + int'(bs[3]) + int'(bs[4]), 1);
    check("R5 chain hdr from first", int'(bh[0]), 4'b1010);
    check("R4 chain end beat", int'(be[5]) * 2 + int'(ba[5]), 2);
    check("R7 chain irqs", irq_cnt, 3);
    hr(7'(7 * 4), rd); check("R2 chain middle returned", int'(rd[15]), 0);

    // R9: underflow, slot 9 chained, slot 10 not owned
    put_desc(9, mk_w0(1, 0, 0, 4'b0000, 1, 24'h300000), 24'h300000, 16'd2);
    clear_obs(); demand(); settle();
    check("R9 underflow beats", nb, 3);
    check_bytes("R9 underflow data", 24'h300000, 2, 0);
    check("R9 abort end beat", int'(be[2]) * 2 + int'(ba[2]), 3);
    hr(7'(9 * 4 + 3), rd); check("R9 error status", int'(rd), 3);
    hr(7'(9 * 4), rd);     check("R9 owner cleared", int'(rd[15]), 0);
    check("R9 irq despite suppress", irq_cnt, 1);
    hr(7'(10 * 4), rd);     check("R1 unowned word0 untouched", int'(rd), 0);
    hr(7'(10 * 4 + 3), rd); check("R1 unowned status untouched", int'(rd), 0);
    put_desc(10, mk_w0(1, 0, 1, 4'b0011, 0, 24'h310000), 24'h310000, 16'd1);
    clear_obs(); demand(); settle();
    check("R9 repoll beats", nb, 2);
    check("R9 repoll new frame hdr", int'(bs[0]) * 16 + int'(bh[0]), 16 + 3);
    check_bytes("R9 repoll data", 24'h310000, 1, 0);

    // R12: no activity before demand
    put_desc(11, mk_w0(1, 0, 1, 4'b0000, 0, 24'h400000), 24'h400000, 16'd2);
    clear_obs(); repeat (80) @(negedge clk);
    check("R12 idle without demand", nb, 0);
    demand(); settle();
    check("R12 demand starts", nb, 3);

    // R10: reset returns pointer to ring base
    hw(7'h40, 16'd5);
    put_desc(0, mk_w0(1, 0, 1, 4'b0000, 0, 24'h500000), 24'h500000, 16'd1);
    put_desc(12, mk_w0(1, 0, 1, 4'b0000, 0, 24'h510000), 24'h510000, 16'd1);
    pulse_reset();
    hr(7'h40, rd); check("R10 base cleared by reset", int'(rd), 0);
    clear_obs(); demand(); settle();
    check("R10 one frame after reset", nb, 2);
    check_bytes("R10 frame from ring start", 24'h500000, 1, 0);

    // R3: wrap on ring size (base 12, two positions)
    pulse_reset();
    hw(7'h40, 16'd12); hw(7'h41, 16'd1);
    put_desc(12, mk_w0(1, 0, 1, 4'b0000, 0, 24'h600000), 24'h600000, 16'd1);
    put_desc(13, mk_w0(1, 0, 1, 4'b0000, 0, 24'h610000), 24'h610000, 16'd1);
    put_desc(14, mk_w0(1, 0, 1, 4'b0000, 0, 24'h620000), 24'h620000, 16'd1);
    clear_obs(); demand(); settle();
    check("R3 two frames", nb, 4);
    check_bytes("R3 first slot", 24'h600000, 1, 0);
    check_bytes("R3 second slot", 24'h610000, 1, 2);
    hr(7'(14 * 4), rd); check("R3 slot outside ring untouched", int'(rd[15]), 1);
    put_desc(12, mk_w0(1, 0, 1, 4'b0000, 0, 24'h630000), 24'h630000, 16'd1);
    clear_obs(); demand(); settle();
    check("R3 wrapped to base count", nb, 2);
    check_bytes("R3 wrapped to base data", 24'h630000, 1, 0);

    // R3: wrap on marker (base 12, four positions, marker on first)
    pulse_reset();
    hw(7'h40, 16'd12); hw(7'h41, 16'd3);
    put_desc(12, mk_w0(1, 1, 1, 4'b0000, 0, 24'h700000), 24'h700000, 16'd1);
    put_desc(13, mk_w0(1, 0, 1, 4'b0000, 0, 24'h710000), 24'h710000, 16'd1);
    clear_obs(); demand(); settle();
    check("R3 marker stops after one", nb, 2);
    hr(7'(13 * 4), rd); check("R3 slot past marker untouched", int'(rd[15]), 1);
    put_desc(12, mk_w0(1, 1, 1, 4'b0000, 0, 24'h720000), 24'h720000, 16'd1);
    clear_obs(); demand(); settle();
    check_bytes("R3 marker returns to base", 24'h720000, 1, 0);

    finished = 1;
    report();
  end
endmodule